// File: doc/BRIEF.md
# Lockable Clock Channel Control Bank

This block holds one small control entry for every clock consumer channel of a chip: a 4-bit generator select, an enable bit and a write-lock bit. Software reaches all entries through a single indirect port. A write carries a 6-bit channel ID with the new field values. A select-only flag lets a write change which entry is selected without changing the entry itself. A read port always shows the entry of the most recently selected ID. The generator select and enable of every channel are driven out in parallel to the clock distribution logic.

The block sits in two reset domains. A power reset puts every entry into its initial state. A user reset preserves locked entries and applies channel-specific rules. The real-time-counter channel (ID 2) survives a user reset while it is enabled or locked. The watchdog channel (ID 1) takes its power-up values from two bits held in non-volatile configuration, and it reloads part of that state on a user reset when it is not locked. IDs 28 to 63 have no entry.

Top module: `clk_chan_bank`

## Requirements
- R1: After a power reset, every channel other than ID 1 has generator select 0, enable 0 and lock 0, and the read port selects ID 0.
- R2: After a power reset, channel ID 1 has generator select 2, enable equal to `nvmWdtEn`, and lock equal to `nvmWdtKeep`, as sampled during the reset.
- R3: On a user reset, a channel other than ID 1 and ID 2 with lock 0 has its generator select and enable cleared to 0. With lock 1 it is unchanged.
- R4: On a user reset, channel ID 2 clears its generator select and enable only when its lock and enable are both 0. Otherwise it is unchanged.
- R5: On a user reset, channel ID 1 with lock 0 takes generator select 2 and enable equal to `nvmWdtEn`. With lock 1 it is unchanged.
- R6: A user reset never changes the lock bit of any channel.
- R7: A write (`wrValid`=1, `wrSelOnly`=0) to an unlocked channel with ID 0 to 27 loads generator select, enable and lock. The new values appear on the outputs one clock later.
- R8: A write to a channel whose lock is 1 is ignored. Only a power reset clears a lock.
- R9: A write to a reserved ID (28 to 63) changes no channel, and while a reserved ID is selected the read port returns all zeros.
- R10: The read port shows the entry of the ID carried by the last accepted write, from the next cycle on. With `wrSelOnly`=1, the ID is selected but no entry changes. Either reset selects ID 0.
- R11: When power reset and user reset are both active in the same cycle, only the power reset behaviour applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwrRst | input | 1 | Power reset, active high, synchronous |
| userRst | input | 1 | User reset, active high, synchronous |
| nvmWdtEn | input | 1 | Non-volatile watchdog enable bit |
| nvmWdtKeep | input | 1 | Non-volatile watchdog always-on bit |
| wrValid | input | 1 | Write strobe |
| wrSelOnly | input | 1 | Select the ID without changing its entry |
| wrId | input | 6 | Channel ID |
| wrGen | input | 4 | Generator select to write |
| wrEn | input | 1 | Enable to write |
| wrLock | input | 1 | Lock to write |
| rdGen | output | 4 | Generator select of the selected ID |
| rdEn | output | 1 | Enable of the selected ID |
| rdLock | output | 1 | Lock of the selected ID |
| chanGen | output | 112 | Generator select of all channels, 4 bits per channel, channel 0 in the lowest bits |
| chanEn | output | 112/4 = 28 | Enable of all channels, bit n for channel n |

## Verification
Any fault in an entry is visible at the parallel outputs one cycle after the event that caused it. The same fault shows on the read port once the bench selects that ID. A lock that is lost or set by mistake stays hidden until the next write or user reset reaches the channel. For that reason, the bench follows every lock test with a write attempt or a user reset and then compares the full output vectors. A wrong selection register shows only on the read port, so every write is followed by a read-back in the next cycle.

// File: rtl/clk_chan_pkg.sv
package clk_chan_pkg;
  localparam int ID_W  = 6;
  localparam int GEN_W = 4;

  typedef struct packed {
    logic [GEN_W-1:0] gen;
    logic             en;
    logic             lock;
  } chanEntry_t;

  typedef struct packed {
    logic             pwrClr;
    logic             userClr;
    logic             selLoad;
    logic             entryWr;
    logic [ID_W-1:0]  id;
    logic [GEN_W-1:0] gen;
    logic             en;
    logic             lock;
  } ctlStrobe_t;
endpackage

// File: rtl/clk_chan_ctrl.sv
module clk_chan_ctrl
  import clk_chan_pkg::*;
#(
  parameter int NUM_CH = 28
) (
  input  logic             pwrRst,
  input  logic             userRst,
  input  logic             wrValid,
  input  logic             wrSelOnly,
  input  logic [ID_W-1:0]  wrId,
  input  logic [GEN_W-1:0] wrGen,
  input  logic             wrEn,
  input  logic             wrLock,
  output ctlStrobe_t       stb
);
  localparam logic [ID_W-1:0] LAST_ID = ID_W'(NUM_CH - 1);

  logic anyRst;
  logic idValid;

  always_comb begin
    anyRst      = pwrRst | userRst;
    idValid     = (wrId <= LAST_ID);
    stb.pwrClr  = pwrRst;
    stb.userClr = userRst & ~pwrRst;
    stb.selLoad = wrValid & ~anyRst;
    stb.entryWr = wrValid & ~anyRst & ~wrSelOnly & idValid;
    stb.id      = wrId;
    stb.gen     = wrGen;
    stb.en      = wrEn;
    stb.lock    = wrLock;
  end
endmodule

// File: rtl/clk_chan_datapath.sv
module clk_chan_datapath
  import clk_chan_pkg::*;
#(
  parameter int NUM_CH      = 28,
  parameter int WDT_ID      = 1,
  parameter int RTC_ID      = 2,
  parameter int WDT_GEN_RST = 2
) (
  input  logic                    clk,
  input  ctlStrobe_t              stb,
  input  logic                    nvmWdtEn,
  input  logic                    nvmWdtKeep,
  output logic [GEN_W-1:0]        rdGen,
  output logic                    rdEn,
  output logic                    rdLock,
  output logic [NUM_CH*GEN_W-1:0] chanGen,
  output logic [NUM_CH-1:0]       chanEn
);
  localparam logic [GEN_W-1:0] WDT_GEN = GEN_W'(WDT_GEN_RST);

  chanEntry_t      entries [NUM_CH];
  logic [ID_W-1:0] selId;
  chanEntry_t      rdEntry;

  always_ff @(posedge clk) begin
    if (stb.pwrClr || stb.userClr) selId <= '0;
    else if (stb.selLoad)          selId <= stb.id;
  end

  always_comb begin
    rdEntry = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (selId == ID_W'(i)) rdEntry = entries[i];
  end

  assign rdGen  = rdEntry.gen;
  assign rdEn   = rdEntry.en;
  assign rdLock = rdEntry.lock;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    localparam logic [ID_W-1:0] MY_ID = ID_W'(ch);
    logic wrHit;
    assign wrHit = stb.entryWr && (stb.id == MY_ID) && !entries[ch].lock;

    if (ch == WDT_ID) begin : g_wdt
      always_ff @(posedge clk) begin
        if (stb.pwrClr) begin
          entries[ch].gen  <= WDT_GEN;
          entries[ch].en   <= nvmWdtEn;
          entries[ch].lock <= nvmWdtKeep;
        end else if (stb.userClr) begin
          if (!entries[ch].lock) begin
            entries[ch].gen <= WDT_GEN;
            entries[ch].en  <= nvmWdtEn;
          end
        end else if (wrHit) begin
          entries[ch] <= '{gen: stb.gen, en: stb.en, lock: stb.lock};
        end
      end

      assert_wdt_power_R2: assert property (@(posedge clk) disable iff (stb.pwrClr)
        $fell(stb.pwrClr) |-> (entries[ch].gen == WDT_GEN &&
                               entries[ch].en == $past(nvmWdtEn) &&
                               entries[ch].lock == $past(nvmWdtKeep)));
      assert_wdt_user_R5: assert property (@(posedge clk) disable iff (stb.pwrClr)
        (stb.userClr && !entries[ch].lock) |=> (entries[ch].gen == WDT_GEN &&
                                                entries[ch].en == $past(nvmWdtEn)));
    end else if (ch == RTC_ID) begin : g_rtc
      always_ff @(posedge clk) begin
        if (stb.pwrClr) begin
          entries[ch] <= '0;
        end else if (stb.userClr) begin
          if (!entries[ch].lock && !entries[ch].en) begin
            entries[ch].gen <= '0;
            entries[ch].en  <= 1'b0;
          end
        end else if (wrHit) begin
          entries[ch] <= '{gen: stb.gen, en: stb.en, lock: stb.lock};
        end
      end

      assert_rtc_keep_R4: assert property (@(posedge clk) disable iff (stb.pwrClr)
        (stb.userClr && (entries[ch].lock || entries[ch].en)) |=>
          ($stable(entries[ch].gen) && $stable(entries[ch].en)));
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (stb.pwrClr) begin
          entries[ch] <= '0;
        end else if (stb.userClr) begin
          if (!entries[ch].lock) begin
            entries[ch].gen <= '0;
            entries[ch].en  <= 1'b0;
          end
        end else if (wrHit) begin
          entries[ch] <= '{gen: stb.gen, en: stb.en, lock: stb.lock};
        end
      end

      assert_plain_user_R3: assert property (@(posedge clk) disable iff (stb.pwrClr)
        (stb.userClr && !entries[ch].lock) |=> (entries[ch].gen == '0 && !entries[ch].en));
    end

    assign chanGen[ch*GEN_W +: GEN_W] = entries[ch].gen;
    assign chanEn[ch]                 = entries[ch].en;

    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (stb.pwrClr)
      entries[ch].lock |=> entries[ch].lock);
    assert_locked_write_R8: assert property (@(posedge clk) disable iff (stb.pwrClr)
      (stb.entryWr && stb.id == MY_ID && entries[ch].lock) |=>
        ($stable(entries[ch].gen) && $stable(entries[ch].en)));
    assert_user_lock_R6: assert property (@(posedge clk) disable iff (stb.pwrClr)
      stb.userClr |=> $stable(entries[ch].lock));
  end
endmodule

// File: rtl/clk_chan_bank.sv
module clk_chan_bank
  import clk_chan_pkg::*;
#(
  parameter int NUM_CH      = 28,
  parameter int WDT_ID      = 1,
  parameter int RTC_ID      = 2,
  parameter int WDT_GEN_RST = 2
) (
  input  logic                    clk,
  input  logic                    pwrRst,
  input  logic                    userRst,
  input  logic                    nvmWdtEn,
  input  logic                    nvmWdtKeep,
  input  logic                    wrValid,
  input  logic                    wrSelOnly,
  input  logic [ID_W-1:0]         wrId,
  input  logic [GEN_W-1:0]        wrGen,
  input  logic                    wrEn,
  input  logic                    wrLock,
  output logic [GEN_W-1:0]        rdGen,
  output logic                    rdEn,
  output logic                    rdLock,
  output logic [NUM_CH*GEN_W-1:0] chanGen,
  output logic [NUM_CH-1:0]       chanEn
);
  ctlStrobe_t stb;

  clk_chan_ctrl #(.NUM_CH(NUM_CH)) i_ctrl (
    .pwrRst(pwrRst), .userRst(userRst), .wrValid(wrValid), .wrSelOnly(wrSelOnly),
    .wrId(wrId), .wrGen(wrGen), .wrEn(wrEn), .wrLock(wrLock), .stb(stb)
  );

  clk_chan_datapath #(
    .NUM_CH(NUM_CH), .WDT_ID(WDT_ID), .RTC_ID(RTC_ID), .WDT_GEN_RST(WDT_GEN_RST)
  ) i_data (
    .clk(clk), .stb(stb), .nvmWdtEn(nvmWdtEn), .nvmWdtKeep(nvmWdtKeep),
    .rdGen(rdGen), .rdEn(rdEn), .rdLock(rdLock), .chanGen(chanGen), .chanEn(chanEn)
  );

  assert_both_reset_R11: assert property (@(posedge clk)
    (pwrRst && userRst) |=> (rdGen == '0 && !rdEn && !rdLock));
endmodule

// File: tb/test_clk_chan_bank.sv
module test_clk_chan_bank;
  localparam int NCH = 28;

  logic clk = 1'b0;
  logic pwrRst = 1'b1, userRst = 1'b0, nvmWdtEn = 1'b0, nvmWdtKeep = 1'b0;
  logic wrValid = 1'b0, wrSelOnly = 1'b0, wrEn = 1'b0, wrLock = 1'b0;
  logic [5:0] wrId = '0;
  logic [3:0] wrGen = '0;
  logic [3:0] rdGen;
  logic rdEn, rdLock;
  logic [NCH*4-1:0] chanGen;
  logic [NCH-1:0] chanEn;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  clk_chan_bank i_clk_chan_bank (
    .clk(clk), .pwrRst(pwrRst), .userRst(userRst), .nvmWdtEn(nvmWdtEn),
    .nvmWdtKeep(nvmWdtKeep), .wrValid(wrValid), .wrSelOnly(wrSelOnly), .wrId(wrId),
    .wrGen(wrGen), .wrEn(wrEn), .wrLock(wrLock), .rdGen(rdGen), .rdEn(rdEn),
    .rdLock(rdLock), .chanGen(chanGen), .chanEn(chanEn)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] genOf(input int ch);
    return chanGen[ch*4 +: 4];
  endfunction

  task automatic pulsePwr(input logic nEn, input logic nKeep);
    nvmWdtEn = nEn; nvmWdtKeep = nKeep; pwrRst = 1'b1;
    @(negedge clk);
    pwrRst = 1'b0;
  endtask

  task automatic pulseUser();
    userRst = 1'b1;
    @(negedge clk);
    userRst = 1'b0;
  endtask

  task automatic doWrite(input logic [5:0] id, input logic [3:0] g, input logic e,
                         input logic l, input logic selOnly);
    wrValid = 1'b1; wrId = id; wrGen = g; wrEn = e; wrLock = l; wrSelOnly = selOnly;
    @(negedge clk);
    wrValid = 1'b0; wrSelOnly = 1'b0;
  endtask

  task automatic chkRead(input string req, input logic [3:0] g, input logic e, input logic l);
    chk(req, "rd", {rdGen, rdEn, rdLock}, {g, e, l});
  endtask

  task automatic t_power();
    pulsePwr(1'b1, 1'b0);
    chk("R1", "ch0", {genOf(0), chanEn[0]}, 0);
    chk("R1", "ch27", {genOf(27), chanEn[27]}, 0);
    chk("R1", "enables", chanEn & ~28'h2, 0);
    chkRead("R1", 4'h0, 1'b0, 1'b0);
    chk("R2", "wdt gen/en", {genOf(1), chanEn[1]}, {4'h2, 1'b1});
    doWrite(6'd1, 4'h0, 1'b0, 1'b0, 1'b1);
    chkRead("R2", 4'h2, 1'b1, 1'b0);
    pulsePwr(1'b0, 1'b1);
    doWrite(6'd1, 4'h0, 1'b0, 1'b0, 1'b1);
    chkRead("R2", 4'h2, 1'b0, 1'b1);
  endtask

  task automatic t_write();
    pulsePwr(1'b0, 1'b0);
    doWrite(6'd5, 4'h7, 1'b1, 1'b0, 1'b0);
    chk("R7", "ch5", {genOf(5), chanEn[5]}, {4'h7, 1'b1});
    chkRead("R10", 4'h7, 1'b1, 1'b0);
    doWrite(6'd27, 4'hF, 1'b1, 1'b1, 1'b0);
    chk("R7", "ch27", {genOf(27), chanEn[27]}, {4'hF, 1'b1});
    chkRead("R7", 4'hF, 1'b1, 1'b1);
  endtask

  task automatic t_lock();
    pulsePwr(1'b0, 1'b0);
    doWrite(6'd5, 4'h3, 1'b1, 1'b1, 1'b0);
    doWrite(6'd5, 4'h9, 1'b0, 1'b0, 1'b0);
    chk("R8", "locked ch5", {genOf(5), chanEn[5]}, {4'h3, 1'b1});
    chkRead("R8", 4'h3, 1'b1, 1'b1);
    doWrite(6'd6, 4'h4, 1'b1, 1'b0, 1'b0);
    pulseUser();
    chk("R3", "locked ch5 kept", {genOf(5), chanEn[5]}, {4'h3, 1'b1});
    chk("R3", "unlocked ch6 cleared", {genOf(6), chanEn[6]}, 0);
    doWrite(6'd5, 4'h0, 1'b0, 1'b0, 1'b1);
    chkRead("R6", 4'h3, 1'b1, 1'b1);
    pulsePwr(1'b0, 1'b0);
    doWrite(6'd5, 4'hA, 1'b0, 1'b0, 1'b0);
    chkRead("R8", 4'hA, 1'b0, 1'b0);
  endtask

  task automatic t_rtc();
    pulsePwr(1'b0, 1'b0);
    doWrite(6'd2, 4'h5, 1'b1, 1'b0, 1'b0);
    pulseUser();
    chk("R4", "rtc enabled kept", {genOf(2), chanEn[2]}, {4'h5, 1'b1});
    doWrite(6'd2, 4'h5, 1'b0, 1'b0, 1'b0);
    pulseUser();
    chk("R4", "rtc idle cleared", {genOf(2), chanEn[2]}, 0);
    doWrite(6'd2, 4'h6, 1'b0, 1'b1, 1'b0);
    pulseUser();
    chk("R4", "rtc locked kept", {genOf(2), chanEn[2]}, {4'h6, 1'b0});
    doWrite(6'd2, 4'h0, 1'b0, 1'b0, 1'b1);
    chkRead("R6", 4'h6, 1'b0, 1'b1);
  endtask

  task automatic t_wdt();
    pulsePwr(1'b1, 1'b0);
    doWrite(6'd1, 4'h9, 1'b0, 1'b0, 1'b0);
    nvmWdtEn = 1'b1;
    pulseUser();
    chk("R5", "wdt reload en1", {genOf(1), chanEn[1]}, {4'h2, 1'b1});
    doWrite(6'd1, 4'h9, 1'b1, 1'b0, 1'b0);
    nvmWdtEn = 1'b0;
    pulseUser();
    chk("R5", "wdt reload en0", {genOf(1), chanEn[1]}, {4'h2, 1'b0});
    doWrite(6'd1, 4'hB, 1'b1, 1'b1, 1'b0);
    pulseUser();
    chk("R5", "wdt locked kept", {genOf(1), chanEn[1]}, {4'hB, 1'b1});
    doWrite(6'd1, 4'h0, 1'b0, 1'b0, 1'b1);
    chkRead("R6", 4'hB, 1'b1, 1'b1);
  endtask

  task automatic t_reserved();
    logic [NCH*4-1:0] gBefore;
    logic [NCH-1:0]   eBefore;
    pulsePwr(1'b0, 1'b0);
    doWrite(6'd3, 4'h8, 1'b1, 1'b0, 1'b0);
    gBefore = chanGen; eBefore = chanEn;
    doWrite(6'h30, 4'h5, 1'b1, 1'b0, 1'b0);
    chkRead("R9", 4'h0, 1'b0, 1'b0);
    doWrite(6'h1C, 4'h5, 1'b1, 1'b1, 1'b0);
    chkRead("R9", 4'h0, 1'b0, 1'b0);
    chk("R9", "gen vector", chanGen, gBefore);
    chk("R9", "en vector", chanEn, eBefore);
  endtask

  task automatic t_select();
    pulsePwr(1'b0, 1'b0);
    doWrite(6'd5, 4'h8, 1'b1, 1'b0, 1'b0);
    doWrite(6'd6, 4'h3, 1'b1, 1'b1, 1'b1);
    chk("R10", "sel-only ch6 unchanged", {genOf(6), chanEn[6]}, 0);
    chkRead("R10", 4'h0, 1'b0, 1'b0);
    doWrite(6'd5, 4'h1, 1'b0, 1'b1, 1'b1);
    chkRead("R10", 4'h8, 1'b1, 1'b0);
    doWrite(6'd0, 4'hC, 1'b1, 1'b0, 1'b0);
    doWrite(6'd5, 4'h0, 1'b0, 1'b0, 1'b1);
    pulseUser();
    chkRead("R10", 4'h0, 1'b0, 1'b0);
  endtask

  task automatic t_both();
    pulsePwr(1'b0, 1'b0);
    doWrite(6'd7, 4'h4, 1'b1, 1'b1, 1'b0);
    doWrite(6'd1, 4'h6, 1'b1, 1'b0, 1'b0);
    nvmWdtEn = 1'b0; nvmWdtKeep = 1'b1;
    pwrRst = 1'b1; userRst = 1'b1;
    @(negedge clk);
    pwrRst = 1'b0; userRst = 1'b0;
    chk("R11", "ch7 cleared", {genOf(7), chanEn[7]}, 0);
    doWrite(6'd7, 4'h0, 1'b0, 1'b0, 1'b1);
    chkRead("R11", 4'h0, 1'b0, 1'b0);
    doWrite(6'd1, 4'h0, 1'b0, 1'b0, 1'b1);
    chkRead("R11", 4'h2, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_power();
    t_write();
    t_lock();
    t_rtc();
    t_wdt();
    t_reserved();
    t_select();
    t_both();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule